// File: doc/BRIEF.md
# Nth-Chance Clock Eviction Selector

This block picks which page frame to give up when a new page must come into memory. The frames sit on a ring, and a hand register marks the frame to be looked at next. Every read or write hit and every fresh load marks a frame as recently used. When a victim is requested, the hand walks the ring one frame per cycle. It strips the recent-use marks as it goes, and it only gives up a frame that has gone unused for a set number of visits by the hand. It then reports that frame's index and parks just past it.

The number of unused visits a frame must receive before it qualifies is the parameter `CHANCES`. A value of 1 gives the classic second-chance policy. Larger values bring the choice closer to least-recently-used order, at the cost of longer searches. A per-frame lock input keeps pinned frames, such as kernel pages or I/O buffers, out of the search. If every frame is pinned, the block reports an error after one revolution instead of spinning forever.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, the hand is 0, busy is low, victimValid and allLockedErr are low, and every frame has its used mark clear and its pass count at 0.
- R2: An access strobe or a load strobe to a frame sets that frame's used mark and resets its pass count to 0. Both strobes may name different frames in the same cycle.
- R3: A victimReq seen while idle raises busy on the next cycle. While busy, the hand examines one frame per cycle and advances by one each cycle, wrapping from NUM_FRAMES-1 to 0. While idle, the hand holds.
- R4: An unlocked frame under the hand whose used mark is set has the mark cleared, and the hand moves on without choosing it.
- R5: An unlocked frame under the hand with its mark clear is chosen on its CHANCES-th consecutive such visit. On earlier visits its pass count is incremented and the hand moves on. With CHANCES = 1, the first such visit chooses it. A chosen frame's pass count returns to 0.
- R6: A frame whose lockMask bit is 1 when the hand reaches it is passed over and its state is left unchanged. It is never reported as a victim.
- R7: If the search meets NUM_FRAMES locked frames in a row, it ends with a one-cycle allLockedErr pulse. The hand is then back where the search began, and busy drops.
- R8: When a victim is chosen, victimValid pulses for one cycle with victimIdx holding the frame index. At the same time busy drops and the hand equals victimIdx+1, wrapping to 0.
- R9: An access or load strobe to the frame under the hand in the cycle it is examined takes priority. That frame keeps its mark set, is not chosen, and the search continues.
- R10: victimReq while busy is ignored; it neither restarts nor extends the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessValid | input | 1 | A frame was read or written this cycle |
| accessIdx | input | IDX_W | Index of the accessed frame |
| loadValid | input | 1 | A frame was loaded this cycle |
| loadIdx | input | IDX_W | Index of the loaded frame |
| lockMask | input | NUM_FRAMES | 1 = frame pinned, not evictable |
| victimReq | input | 1 | Start a victim search (taken while idle) |
| busy | output | 1 | Search in progress |
| victimValid | output | 1 | One-cycle pulse: victimIdx is valid |
| victimIdx | output | IDX_W | Chosen frame |
| allLockedErr | output | 1 | One-cycle pulse: all frames locked, no victim |
| hand | output | IDX_W | Frame to be examined next |

## Verification
The assertions check the hand's motion on every cycle: a single wrapped step while busy and no motion while idle. They also check that a victim leaves the hand one frame past it, that a completion pulse follows a busy cycle, and that a frame locked when examined is never reported. Which frame is chosen depends on the history of used marks and pass counts, on same-cycle reference priority, and on ignored requests. Those are shown only by the bench's directed scenarios and its cycle-by-cycle comparison against a behavioural model under random traffic.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  // Strobes from the sweep controller to the frame datapath
  typedef struct packed {
    logic advance;   // move hand to next frame
    logic clearRef;  // clear used mark of frame under hand
    logic bumpCnt;   // increment pass count of frame under hand
    logic pick;      // frame under hand is the victim
    logic fail;      // full revolution of locked frames
  } sweepStrobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } sweepState_t;

endpackage

// File: rtl/clock_sweep_dp.sv
module clock_sweep_dp
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CHANCES    = 2,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  parameter int CNT_W      = (CHANCES > 1) ? $clog2(CHANCES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accessValid,
  input  logic [IDX_W-1:0]      accessIdx,
  input  logic                  loadValid,
  input  logic [IDX_W-1:0]      loadIdx,
  input  logic [NUM_FRAMES-1:0] lockMask,
  input  sweepStrobe_t          strobe,
  output logic                  curRef,
  output logic                  curExpire,
  output logic                  curLocked,
  output logic [IDX_W-1:0]      hand,
  output logic [IDX_W-1:0]      victimIdx
);

  localparam logic [CNT_W-1:0] PassLimit = CNT_W'(CHANCES - 1);
  localparam logic [IDX_W-1:0] LastIdx   = IDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] refBits;
  logic [NUM_FRAMES-1:0] hitVec;
  logic [CNT_W-1:0]      passCnt [NUM_FRAMES];
  logic [IDX_W-1:0]      nextHand;

  always_comb begin
    for (int i = 0; i < NUM_FRAMES; i++) begin
      hitVec[i] = (accessValid && (accessIdx == IDX_W'(i))) ||
                  (loadValid   && (loadIdx   == IDX_W'(i)));
    end
  end

  // Reference update takes priority over the sweep (hitVec folded in)
  assign curRef    = refBits[hand] | hitVec[hand];
  assign curExpire = (passCnt[hand] == PassLimit);
  assign curLocked = lockMask[hand];
  assign nextHand  = (hand == LastIdx) ? '0 : hand + 1'b1;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic underHand;
    assign underHand = (hand == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refBits[g] <= 1'b0;
        passCnt[g] <= '0;
      end else if (hitVec[g]) begin
        refBits[g] <= 1'b1;
        passCnt[g] <= '0;
      end else if (underHand) begin
        if (strobe.clearRef) refBits[g] <= 1'b0;
        if (strobe.bumpCnt)  passCnt[g] <= passCnt[g] + 1'b1;
        if (strobe.pick)     passCnt[g] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hand      <= '0;
      victimIdx <= '0;
    end else begin
      if (strobe.advance) hand <= nextHand;
      if (strobe.pick)    victimIdx <= hand;
    end
  end

endmodule

// File: rtl/clock_sweep_ctl.sv
module clock_sweep_ctl
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         victimReq,
  input  logic         curRef,
  input  logic         curExpire,
  input  logic         curLocked,
  output sweepStrobe_t strobe,
  output logic         busy,
  output logic         victimValid,
  output logic         allLockedErr
);

  localparam int SKIP_W = $clog2(NUM_FRAMES + 1);
  localparam logic [SKIP_W-1:0] SkipLast = SKIP_W'(NUM_FRAMES - 1);

  sweepState_t      state;
  logic [SKIP_W-1:0] skipCnt;

  assign busy = (state == ST_SEARCH);

  always_comb begin
    strobe = '0;
    if (state == ST_SEARCH) begin
      strobe.advance = 1'b1;
      if (curLocked) begin
        strobe.fail = (skipCnt == SkipLast);
      end else if (curRef) begin
        strobe.clearRef = 1'b1;
      end else if (curExpire) begin
        strobe.pick = 1'b1;
      end else begin
        strobe.bumpCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      skipCnt      <= '0;
      victimValid  <= 1'b0;
      allLockedErr <= 1'b0;
    end else begin
      victimValid  <= strobe.pick;
      allLockedErr <= strobe.fail;
      case (state)
        ST_IDLE: begin
          skipCnt <= '0;
          if (victimReq) state <= ST_SEARCH;
        end
        ST_SEARCH: begin
          skipCnt <= curLocked ? skipCnt + 1'b1 : '0;
          if (strobe.pick || strobe.fail) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int CHANCES    = 2,
  parameter int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accessValid,
  input  logic [IDX_W-1:0]      accessIdx,
  input  logic                  loadValid,
  input  logic [IDX_W-1:0]      loadIdx,
  input  logic [NUM_FRAMES-1:0] lockMask,
  input  logic                  victimReq,
  output logic                  busy,
  output logic                  victimValid,
  output logic [IDX_W-1:0]      victimIdx,
  output logic                  allLockedErr,
  output logic [IDX_W-1:0]      hand
);

  sweepStrobe_t strobe;
  logic curRef, curExpire, curLocked;

  clock_sweep_ctl #(.NUM_FRAMES(NUM_FRAMES)) u_ctl (
    .clk(clk), .rstN(rstN), .victimReq(victimReq),
    .curRef(curRef), .curExpire(curExpire), .curLocked(curLocked),
    .strobe(strobe), .busy(busy), .victimValid(victimValid),
    .allLockedErr(allLockedErr)
  );

  clock_sweep_dp #(.NUM_FRAMES(NUM_FRAMES), .CHANCES(CHANCES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .accessValid(accessValid), .accessIdx(accessIdx),
    .loadValid(loadValid), .loadIdx(loadIdx), .lockMask(lockMask),
    .strobe(strobe), .curRef(curRef), .curExpire(curExpire),
    .curLocked(curLocked), .hand(hand), .victimIdx(victimIdx)
  );

endmodule

// File: rtl/clock_victim_chk.sv
module clock_victim_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  accessValid,
  input logic [IDX_W-1:0]      accessIdx,
  input logic                  loadValid,
  input logic [IDX_W-1:0]      loadIdx,
  input logic [NUM_FRAMES-1:0] lockMask,
  input logic                  victimReq,
  input logic                  busy,
  input logic                  victimValid,
  input logic [IDX_W-1:0]      victimIdx,
  input logic                  allLockedErr,
  input logic [IDX_W-1:0]      hand
);

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] v);
    return (v == IDX_W'(NUM_FRAMES - 1)) ? '0 : v + 1'b1;
  endfunction

  logic [NUM_FRAMES-1:0] lockQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= '0;
    else       lockQ <= lockMask;
  end

  // R3
  hand_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> hand == stepIdx($past(hand)));

  // R3
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(hand));

  // R8
  victim_hand_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> (hand == stepIdx(victimIdx)) && !busy);

  // R8
  done_after_search_chk: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid || allLockedErr) |-> $past(busy));

  // R8
  done_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(victimValid && allLockedErr));

  // R6
  locked_never_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> !lockQ[victimIdx]);

endmodule

bind clock_victim_sel clock_victim_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;

  localparam int F = 8;
  localparam int N = 2;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accessValid = 1'b0, loadValid = 1'b0, victimReq = 1'b0;
  logic [W-1:0] accessIdx = '0, loadIdx = '0;
  logic [F-1:0] lockMask = '0;
  logic busy, victimValid, allLockedErr;
  logic [W-1:0] victimIdx, hand;

  always #10 clk = ~clk;  // 50 MHz

  clock_victim_sel #(.NUM_FRAMES(F), .CHANCES(N)) dut (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .accessIdx(accessIdx),
    .loadValid(loadValid), .loadIdx(loadIdx), .lockMask(lockMask),
    .victimReq(victimReq), .busy(busy), .victimValid(victimValid),
    .victimIdx(victimIdx), .allLockedErr(allLockedErr), .hand(hand)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit cmpOn = 0;

  // Behavioural reference model
  int mRef[F], mCnt[F];
  int mHand = 0, mIdx = 0, mSkip = 0;
  bit mBusy = 0, mValid = 0, mErr = 0;
  bit hitv[F];

  always @(posedge clk) begin
    for (int i = 0; i < F; i++)
      hitv[i] = (accessValid && accessIdx == W'(i)) || (loadValid && loadIdx == W'(i));
    mValid = 0; mErr = 0;
    if (!rstN) begin
      for (int i = 0; i < F; i++) begin mRef[i] = 0; mCnt[i] = 0; end
      mHand = 0; mIdx = 0; mSkip = 0; mBusy = 0;
    end else begin
      if (mBusy) begin
        int h;
        h = mHand;
        if (lockMask[h]) begin
          if (mSkip == F - 1) begin mErr = 1; mBusy = 0; end
          mSkip++;
        end else begin
          mSkip = 0;
          if (mRef[h] != 0 || hitv[h]) mRef[h] = 0;
          else if (mCnt[h] == N - 1) begin
            mValid = 1; mIdx = h; mCnt[h] = 0; mBusy = 0;
          end else mCnt[h]++;
        end
        mHand = (h + 1) % F;
      end else if (victimReq) begin
        mBusy = 1; mSkip = 0;
      end
      for (int i = 0; i < F; i++)
        if (hitv[i]) begin mRef[i] = 1; mCnt[i] = 0; end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check(phase, "busy", busy, mBusy);
      check(phase, "victimValid", victimValid, mValid);
      check(phase, "allLockedErr", allLockedErr, mErr);
      check(phase, "hand", hand, mHand);
      check(phase, "victimIdx", victimIdx, mIdx);
    end
  end

  task automatic idleIn();
    accessValid = 0; loadValid = 0; victimReq = 0;
  endtask

  // Pulse a request and wait for completion; returns index and error flag
  task automatic runSearch(output int idx, output bit err);
    @(negedge clk); victimReq = 1;
    @(negedge clk); victimReq = 0;
    idx = -1; err = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (victimValid) begin idx = victimIdx; break; end
      if (allLockedErr) begin err = 1; break; end
    end
  endtask

  task automatic loadAll();
    for (int i = 0; i < F; i++) begin
      @(negedge clk); loadValid = 1; loadIdx = W'(i);
    end
    @(negedge clk); loadValid = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int idx, cnt;
    bit err;
    idleIn();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "hand", hand, 0);
    check("R1", "busy", busy, 0);
    check("R1", "victimValid", victimValid, 0);
    check("R1", "allLockedErr", allLockedErr, 0);
    rstN = 1; cmpOn = 1;

    // R5: fresh frames, each needs N unreferenced visits -> frame 0 after full pass
    phase = "R5";
    runSearch(idx, err);
    check("R5", "first victim", idx, 0);
    check("R8", "hand after victim", hand, 1);

    // R2/R4: load all, first pass clears marks, second bumps, third picks
    phase = "R4";
    loadAll();
    runSearch(idx, err);
    check("R4", "victim after loads", idx, 1);

    // R6: frame 2 locked and skipped, frame 3 chosen
    phase = "R6";
    lockMask = 8'b0000_0100;
    runSearch(idx, err);
    check("R6", "victim skips locked", idx, 3);
    lockMask = '0;

    // R9: access to frame 4 while it is examined keeps it
    phase = "R9";
    @(negedge clk); victimReq = 1;
    @(negedge clk); victimReq = 0; accessValid = 1; accessIdx = 3'd4;
    @(negedge clk); accessValid = 0;
    idx = -1;
    for (int k = 0; k < 40; k++) begin
      if (victimValid) begin idx = victimIdx; break; end
      @(negedge clk);
    end
    check("R9", "victim after same-cycle access", idx, 5);

    // R7: everything locked
    phase = "R7";
    lockMask = '1;
    runSearch(idx, err);
    check("R7", "error flag", err, 1);
    check("R7", "hand back at start", hand, 6);
    lockMask = '0;

    // R10: extra requests while busy are ignored
    phase = "R10";
    loadAll();
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (victimValid) cnt++;
      victimReq = (k == 0 || k == 2 || k == 4);
    end
    victimReq = 0;
    check("R10", "victims from one search", cnt, 1);

    // R2/R3/R9: random traffic against the model
    phase = "R2";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      accessValid = ($urandom_range(0, 2) == 0);
      accessIdx   = W'($urandom_range(0, F - 1));
      loadValid   = ($urandom_range(0, 5) == 0);
      loadIdx     = W'($urandom_range(0, F - 1));
      victimReq   = ($urandom_range(0, 7) == 0);
      lockMask    = ($urandom_range(0, 99) == 0) ? '1 :
                    F'($urandom & $urandom & $urandom);
    end
    idleIn(); lockMask = '0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule